// File: doc/BRIEF.md
# Interval Tick and Time-of-Year Counter

This block divides the system clock down to a fixed rate of 100 ticks per second, one tick every 10 ms. Each tick can raise a periodic interrupt request, gated by an enable bit in a small control register. The same tick advances a 32-bit time-of-year counter whose unit is one 10 ms tick. A battery-low flag holds that counter still until software loads it with a nonzero value.

Software reaches two registers through write and read strobes. One is the interval control register, which holds the interrupt enable. The other is the time-of-year register. The block has two resets:

- Power-up (`por_n`) brings up the whole block. It sets battery-low and presets the counter to `TOY_INIT`.
- The ordinary system reset (`rst_n`) clears the enable, the pending request and the tick phase. It does not touch the time-of-year value or the battery flag.

Two state machines carry the control:

- **Interrupt machine.** States `IRQ_IDLE` and `IRQ_PEND`.
  - Transition `raise` (IDLE→PEND) fires on a tick while the enable is set and no write clears the enable in that cycle.
  - Transition `clear` (PEND→IDLE) fires on a control write with bit 6 = 0, or on an acknowledge that does not coincide with a new enabled tick.
- **Battery machine.** States `BATT_LOW` and `BATT_OK`.
  - Transition `restore` (LOW→OK) fires on a nonzero write to the time-of-year register.
  - Only power-up returns it to `BATT_LOW`.

Top module: `tick_toy_timer`

## Requirements
- R1: With DIV = CLK_HZ/TICK_HZ, a tick occurs on every DIV-th rising clock edge. Counting the first edge at which both resets are sampled high as edge 1, the first tick is on edge DIV. No tick occurs while either reset is low.
- R2: The control register implements only bit 6 (interrupt enable), which is written from `wr_data[6]` when `ctl_wr` is high. Reading it returns the enable in bit 6 and 0 in all other bits.
- R3: A tick with the enable set asserts `irq` from that clock edge. A tick with the enable clear raises nothing.
- R4: `irq` stays high until `irq_ack` or a control write with bit 6 = 0. When a control write with bit 6 = 0 coincides with a tick, `irq` ends low. When `irq_ack` coincides with an enabled tick, `irq` stays high.
- R5: With `por_n` high, `rst_n` low clears the enable, `irq` and the tick phase. It leaves the time-of-year value and battery flag unchanged.
- R6: Power-up sets battery-low and loads `TOY_INIT` (default 0x1000_0000). While battery-low is set, the counter does not advance on ticks.
- R7: A write of any nonzero value to the time-of-year register loads it and clears battery-low. The value then advances by one on each later tick.
- R8: The counter increments by one per tick only while it is nonzero and battery-low is clear. A write of 0 loads 0, which stops it.
- R9: From 0xFFFF_FFFF a tick takes the counter to 0, where it stays.
- R10: `rd_data` shows the control register when `rd_ctl` is high (taking priority), the time-of-year value when only `rd_toy` is high, and 0 when neither is high.
- R11: A time-of-year write in the same cycle as a tick loads the written value with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Synchronous power-up reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low |
| ctl_wr | input | 1 | Write strobe for the control register |
| toy_wr | input | 1 | Write strobe for the time-of-year register |
| wr_data | input | 32 | Write data for both registers |
| rd_ctl | input | 1 | Read select for the control register |
| rd_toy | input | 1 | Read select for the time-of-year register |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interval interrupt request |
| rd_data | output | 32 | Read data |

## Verification
The hardest situations to reach from the ports are the collisions with a tick: an acknowledge, an enable-clearing write or a counter write landing on exactly the tick edge. The bench reaches them by stepping until its own phase model says the next edge carries a tick, and then applying the strobe there. The 32-bit wrap would need billions of ticks, so the stimulus loads values just below the top and lets a few ticks carry the counter over. Battery-low gating is only visible because the power-up preset is nonzero. The bench therefore reads that preset across several ticks before any write, and the random phase fires further power-up pulses.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic {IRQ_IDLE, IRQ_PEND} irq_state_t;
    typedef enum logic {BATT_LOW, BATT_OK} batt_state_t;
    localparam int CTL_IE_BIT = 6;
endpackage

// File: rtl/tt_tick_div.sv
module tt_tick_div #(
    parameter int DIV = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = rst_n && (cnt_q == LAST);

    // R1: phase counter never leaves its range
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R1: ticks are isolated single-cycle pulses
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tt_irq_ctrl.sv
module tt_irq_ctrl
    import tt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ctl_wr_i,
    input  logic ie_wdata_i,
    input  logic ack_i,
    output logic ie_o,
    output logic irq_o
);
    irq_state_t state_q, state_d;
    logic       ie_q;
    logic       clr_wr;
    logic       raise;

    assign clr_wr = ctl_wr_i && !ie_wdata_i;
    assign raise  = tick_i && ie_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            ie_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctl_wr_i)
                ie_q <= ie_wdata_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise && !clr_wr) state_d = IRQ_PEND;
            IRQ_PEND: if (clr_wr || (ack_i && !raise)) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_PEND);
        ie_o  = ie_q;
    end

    // R3: a request only appears after an enabled tick
    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick_i) && $past(ie_q));
    // R4: enable-clearing write always drops the request
    a_r4_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !irq_o);
    // R4: acknowledge without a fresh enabled tick drops the request
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !raise) |=> !irq_o);
    // R4: pending request holds without ack or clearing write
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && !clr_wr) |=> irq_o);
endmodule

// File: rtl/tt_toy_counter.sv
module tt_toy_counter
    import tt_pkg::*;
#(
    parameter int          TOY_W    = 32,
    parameter logic [31:0] TOY_INIT = 32'h1000_0000
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [TOY_W-1:0] wdata_i,
    output logic [TOY_W-1:0] toy_o
);
    batt_state_t      batt_q, batt_d;
    logic [TOY_W-1:0] toy_q;
    logic             run;

    assign run = tick_i && (batt_q == BATT_OK) && (toy_q != '0);

    always_ff @(posedge clk) begin
        if (!por_n)
            batt_q <= BATT_LOW;
        else
            batt_q <= batt_d;
    end

    always_comb begin
        batt_d = batt_q;
        unique case (batt_q)
            BATT_LOW: if (wr_i && (wdata_i != '0)) batt_d = BATT_OK;
            BATT_OK:  batt_d = BATT_OK;
            default:  batt_d = BATT_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!por_n)
            toy_q <= TOY_W'(TOY_INIT);
        else if (wr_i)
            toy_q <= wdata_i;
        else if (run)
            toy_q <= toy_q + 1'b1;
    end

    assign toy_o = toy_q;

    // R6: battery-low freezes the value
    a_r6_hold_low: assert property (@(posedge clk) disable iff (!por_n)
        (batt_q == BATT_LOW && !wr_i) |=> $stable(toy_q));
    // R7: nonzero write loads and restores the battery flag
    a_r7_load: assert property (@(posedge clk) disable iff (!por_n)
        (wr_i && wdata_i != '0) |=> (batt_q == BATT_OK) && (toy_q == $past(wdata_i)));
    // R8: zero is sticky without a write
    a_r8_zero_stops: assert property (@(posedge clk) disable iff (!por_n)
        (toy_q == '0 && !wr_i) |=> toy_q == '0);
    // R9: wrap from all ones lands on zero
    a_r9_wrap: assert property (@(posedge clk) disable iff (!por_n)
        (toy_q == '1 && tick_i && batt_q == BATT_OK && !wr_i) |=> toy_q == '0);
endmodule

// File: rtl/tick_toy_timer.sv
module tick_toy_timer
    import tt_pkg::*;
#(
    parameter int          CLK_HZ   = 100000000,
    parameter int          TICK_HZ  = 100,
    parameter int          TOY_W    = 32,
    parameter logic [31:0] TOY_INIT = 32'h1000_0000
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             toy_wr,
    input  logic [TOY_W-1:0] wr_data,
    input  logic             rd_ctl,
    input  logic             rd_toy,
    input  logic             irq_ack,
    output logic             irq,
    output logic [TOY_W-1:0] rd_data
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic             sys_rst_n;
    logic             tick;
    logic             ie;
    logic [TOY_W-1:0] toy;

    assign sys_rst_n = por_n && rst_n;

    tt_tick_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .tick_o (tick)
    );

    tt_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .tick_i     (tick),
        .ctl_wr_i   (ctl_wr),
        .ie_wdata_i (wr_data[CTL_IE_BIT]),
        .ack_i      (irq_ack),
        .ie_o       (ie),
        .irq_o      (irq)
    );

    tt_toy_counter #(.TOY_W(TOY_W), .TOY_INIT(TOY_INIT)) u_toy (
        .clk     (clk),
        .por_n   (por_n),
        .tick_i  (tick),
        .wr_i    (toy_wr),
        .wdata_i (wr_data),
        .toy_o   (toy)
    );

    always_comb begin
        rd_data = '0;
        if (rd_ctl)
            rd_data[CTL_IE_BIT] = ie;
        else if (rd_toy)
            rd_data = toy;
    end

    // R10: idle read bus is zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!por_n)
        (!rd_ctl && !rd_toy) |-> rd_data == '0);
    // R2: control read exposes at most the enable bit
    a_r2_ctl_bits: assert property (@(posedge clk) disable iff (!por_n)
        rd_ctl |-> $countones(rd_data) <= 1 && rd_data[CTL_IE_BIT] == ie);
endmodule

// File: tb/tick_toy_timer_bench.sv
module tick_toy_timer_bench;
    localparam int          CLK_HZ  = 2000;
    localparam int          DIV     = CLK_HZ / 100;
    localparam logic [31:0] INITV   = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        ctl_wr = 1'b0, toy_wr = 1'b0, rd_ctl = 1'b0, rd_toy = 1'b0, irq_ack = 1'b0;
    logic [31:0] wr_data = '0;
    logic        irq;
    logic [31:0] rd_data;

    int tests = 0, fails = 0;
    bit done = 0, mon_en = 0;

    always #2 clk = ~clk;

    tick_toy_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(100), .TOY_W(32), .TOY_INIT(INITV)) u_tick_toy_timer (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .ctl_wr(ctl_wr), .toy_wr(toy_wr),
        .wr_data(wr_data), .rd_ctl(rd_ctl), .rd_toy(rd_toy), .irq_ack(irq_ack),
        .irq(irq), .rd_data(rd_data)
    );

    // reference model built from the requirements
    int          m_cnt = 0;
    bit          m_ie = 0, m_irq = 0, m_bl = 1;
    logic [31:0] m_toy = INITV;

    function automatic bit model_tick(int cnt, logic rn);
        return rn && (cnt == DIV - 1);
    endfunction

    function automatic logic [31:0] exp_read(bit rc, bit rt);
        if (rc) return {25'd0, m_ie, 6'd0};
        if (rt) return m_toy;
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        bit t;
        if (!por_n) begin
            m_bl <= 1; m_toy <= INITV; m_cnt <= 0; m_ie <= 0; m_irq <= 0;
        end else begin
            t = model_tick(m_cnt, rst_n);
            if (!rst_n) begin
                m_cnt <= 0; m_ie <= 0; m_irq <= 0;
            end else begin
                m_cnt <= t ? 0 : m_cnt + 1;
                if (ctl_wr) m_ie <= wr_data[6];
                if (ctl_wr && !wr_data[6]) m_irq <= 0;
                else if (t && m_ie)        m_irq <= 1;
                else if (irq_ack)          m_irq <= 0;
            end
            if (toy_wr) begin
                m_toy <= wr_data;
                if (wr_data != 0) m_bl <= 0;
            end else if (t && !m_bl && m_toy != 0)
                m_toy <= m_toy + 1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        ctl_wr = 0; toy_wr = 0; irq_ack = 0; rd_ctl = 0; rd_toy = 0;
    endtask

    task automatic rd(bit rc, bit rt, string tag, logic [31:0] exp);
        rd_ctl = rc; rd_toy = rt; #1;
        chk(tag, rd_data, exp);
        rd_ctl = 0; rd_toy = 0;
    endtask

    task automatic wait_tick_edge();
        while (!model_tick(m_cnt, rst_n)) nxt();
    endtask

    always @(negedge clk)
        if (mon_en && por_n) chk("R3 irq vs model", {31'd0, irq}, {31'd0, m_irq});

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // power-up
        nxt(); nxt();
        #1 chk("R10 idle read zero", rd_data, 32'd0);
        chk("reset irq low", {31'd0, irq}, 32'd0);
        // release and enable in the first post-reset cycle
        por_n = 1; rst_n = 1; ctl_wr = 1; wr_data = 32'h0000_0040;
        nxt();
        for (int k = 2; k <= DIV; k++) begin
            nxt();
            chk("R1 first tick timing", {31'd0, irq}, {31'd0, k == DIV});
        end
        rd(1, 0, "R2 ctl read", 32'h0000_0040);
        rd(1, 1, "R10 ctl priority", 32'h0000_0040);
        repeat (3 * DIV) nxt();
        rd(0, 1, "R6 battery-low holds preset", INITV);
        irq_ack = 1; nxt();
        chk("R4 ack clears", {31'd0, irq}, 32'd0);
        // R7 load then advance
        toy_wr = 1; wr_data = 32'd5; nxt();
        rd(0, 1, "R7 load", 32'd5);
        repeat (DIV) nxt();
        rd(0, 1, "R7 advance", 32'd6);
        // R9 wrap
        toy_wr = 1; wr_data = 32'hFFFF_FFFF; nxt();
        repeat (DIV) nxt();
        rd(0, 1, "R9 wrap", 32'd0);
        repeat (DIV) nxt();
        rd(0, 1, "R8 zero stays", 32'd0);
        // R5 reset keeps time-of-year
        toy_wr = 1; wr_data = 32'd100; nxt();
        rst_n = 0; nxt();
        rst_n = 1;
        rd(1, 0, "R5 enable cleared", 32'd0);
        chk("R5 irq cleared", {31'd0, irq}, 32'd0);
        rd(0, 1, "R5 toy kept", 32'd100);
        // R11 write on tick edge
        wait_tick_edge();
        toy_wr = 1; wr_data = 32'd77; nxt();
        rd(0, 1, "R11 write beats tick", 32'd77);
        repeat (DIV) nxt();
        rd(0, 1, "R8 increments", 32'd78);
        // R4 ack on an enabled tick keeps irq
        ctl_wr = 1; wr_data = 32'h40; nxt();
        wait_tick_edge();
        irq_ack = 1; nxt();
        chk("R4 ack with tick", {31'd0, irq}, 32'd1);
        // R4 clearing write on tick edge wins
        wait_tick_edge();
        ctl_wr = 1; wr_data = 32'h0; nxt();
        chk("R4 clear write wins", {31'd0, irq}, 32'd0);
        // R3 disabled tick raises nothing
        wait_tick_edge(); nxt();
        chk("R3 disabled tick", {31'd0, irq}, 32'd0);

        // random phase
        mon_en = 1;
        for (int i = 0; i < 30000; i++) begin
            int r;
            nxt();
            r = $urandom % 1000;
            por_n = !(r < 1);
            rst_n = !(r >= 1 && r < 4);
            ctl_wr  = ($urandom % 40) == 0;
            toy_wr  = ($urandom % 150) == 0;
            irq_ack = ($urandom % 25) == 0;
            case ($urandom % 4)
                0: wr_data = 32'd0;
                1: wr_data = 32'hFFFF_FFF8 + ($urandom % 8);
                2: wr_data = $urandom;
                default: wr_data = ($urandom % 2) ? 32'h40 : 32'h0;
            endcase
            rd_ctl = ($urandom % 6) == 0;
            rd_toy = ($urandom % 3) == 0;
            #1;
            if (por_n)
                chk(rd_ctl ? "R2 random ctl read" : "R8 random toy read",
                    rd_data, exp_read(rd_ctl, rd_toy));
        end
        mon_en = 0;
        por_n = 1; rst_n = 1;
        summary();
    end
endmodule